// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches a word carried on dual-rail wires, two rails per bit, and produces a single completion flag. Each bit is marked as carrying a value when either of its rails is high. These per-bit flags feed a multi-input Muller C-element with hysteresis. The flag goes high only after every bit carries a value. It goes low only after every bit has returned to the spacer state, which is both rails low. For any mixture of the two, the flag keeps its previous value. A single flag therefore reports both "the whole word has arrived" and "the whole word has been cleared", which a plain AND over the bits cannot do.

The C-element state is modelled as a register updated on the rising clock edge, so a change at the inputs reaches `done` one clock later. A bit with both rails high is an illegal code. The block raises a registered `err` flag for it and counts that bit as carrying a value in the merge.

Top module: `dual_rail_done`

## Requirements
- R1: While `rst` is high at a rising edge, `done` and `err` are 0 after that edge.
- R2: When every bit carries a value (at least one of `t[i]`, `f[i]` high), `done` is 1 after the next rising edge.
- R3: When every bit is spacer (`t[i]`=0 and `f[i]`=0 for all i), `done` is 0 after the next rising edge.
- R4: When some bits carry a value and others are spacer, `done` keeps the value it had before that edge, whether that value is 0 or 1.
- R5: A bit with both rails high (`t[i]`=1, `f[i]`=1) counts as carrying a value for R2 and R4.
- R6: `err` is 1 after a rising edge at which any bit had both rails high, and 0 after an edge at which no bit did.
- R7: Completion does not depend on the data: bit i coded as logic one (`t[i]`=1, `f[i]`=0) and as logic zero (`t[i]`=0, `f[i]`=1) count the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| t | input | N | True rail of each bit |
| f | input | N | False rail of each bit |
| done | output | 1 | Registered completion flag with hysteresis |
| err | output | 1 | Registered flag for a bit with both rails high |

## Verification
The word is driven with all-spacer patterns, full words of varying data such as all ones, all zeros and alternating codes, and partial words that are reached both from a cleared state and from a complete one. The partial words separate a true C-element from a plain AND or NOR reduction, because only hysteresis holds `done` through them in both directions. Words with an illegal bit, inside a full word and inside a partial one, show that the illegal bit counts as a value and that `err` tracks it edge by edge. A reset applied while `done` is high shows that reset wins over held state.

// File: rtl/drc_pkg.sv
package drc_pkg;
  // Two-rail code of one bit, packed as {true rail, false rail}
  typedef enum logic [1:0] {
    RAIL_SPACER = 2'b00,
    RAIL_ZERO   = 2'b01,
    RAIL_ONE    = 2'b10,
    RAIL_BAD    = 2'b11
  } rail_code_e;

  function automatic logic rail_has_value(input rail_code_e c);
    return (c != RAIL_SPACER);
  endfunction

  function automatic logic rail_illegal(input rail_code_e c);
    return (c == RAIL_BAD);
  endfunction
endpackage

// File: rtl/drc_bit_flags.sv
module drc_bit_flags
  import drc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] t,
  input  logic [N-1:0] f,
  output logic [N-1:0] has_val,
  output logic [N-1:0] bad
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    rail_code_e code;
    assign code       = rail_code_e'({t[i], f[i]});
    assign has_val[i] = rail_has_value(code);
    assign bad[i]     = rail_illegal(code);
  end
endmodule

// File: rtl/drc_celement.sv
module drc_celement #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] in_flags,
  output logic         q
);
  logic all_high;
  logic all_low;
  logic q_next;

  assign all_high = &in_flags;
  assign all_low  = ~|in_flags;

  always_comb begin
    q_next = q;
    if (all_high)     q_next = 1'b1;
    else if (all_low) q_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_next;
  end
endmodule

// File: rtl/drc_err_reg.sv
module drc_err_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] bad,
  output logic         err
);
  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= |bad;
  end
endmodule

// File: rtl/dual_rail_done.sv
module dual_rail_done #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] t,
  input  logic [N-1:0] f,
  output logic         done,
  output logic         err
);
  logic [N-1:0] has_val;
  logic [N-1:0] bad;

  drc_bit_flags #(.N(N)) u_flags (
    .t(t), .f(f), .has_val(has_val), .bad(bad)
  );

  drc_celement #(.N(N)) u_merge (
    .clk(clk), .rst(rst), .in_flags(has_val), .q(done)
  );

  drc_err_reg #(.N(N)) u_err (
    .clk(clk), .rst(rst), .bad(bad), .err(err)
  );
endmodule

// File: rtl/dual_rail_done_chk.sv
module dual_rail_done_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] t,
  input logic [N-1:0] f,
  input logic         done,
  input logic         err
);
  logic [N-1:0] anyv;
  assign anyv = t | f;

  assert_reset_R1: assert property (@(posedge clk) rst |=> (!done && !err));

  assert_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (&anyv) |=> done);

  assert_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (anyv == '0) |=> !done);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!(&anyv) && (|anyv)) |=> $stable(done));

  assert_bad_counts_R5: assert property (@(posedge clk) disable iff (rst)
    ((|(t & f)) && (&anyv)) |=> done);

  assert_err_set_R6: assert property (@(posedge clk) disable iff (rst)
    (|(t & f)) |=> err);

  assert_err_clr_R6: assert property (@(posedge clk) disable iff (rst)
    !(|(t & f)) |=> !err);
endmodule

bind dual_rail_done dual_rail_done_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .t(t), .f(f), .done(done), .err(err)
);

// File: tb/dual_rail_done_tb.sv
module dual_rail_done_tb;
  localparam int N = 8;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  done;
    logic  err;
    string req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] t = '0;
  logic [N-1:0] f = '0;
  logic         done;
  logic         err;

  int   checks = 0;
  int   errors = 0;
  logic model_done = 1'b0;
  exp_t q[$];
  bit   finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_rail_done #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .t(t), .f(f), .done(done), .err(err)
  );

  // Driver: apply one word, predict the result after the next edge
  task automatic drive(input logic r, input logic [N-1:0] tv,
                       input logic [N-1:0] fv, input string req);
    exp_t e;
    logic [N-1:0] v;
    @(negedge clk);
    rst = r; t = tv; f = fv;
    v = tv | fv;
    if (r)              model_done = 1'b0;
    else if (&v)        model_done = 1'b1;
    else if (v == '0)   model_done = 1'b0;
    e.done = model_done;
    e.err  = r ? 1'b0 : |(tv & fv);
    e.req  = req;
    q.push_back(e);
  endtask

  // Monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (done !== e.done) begin
          errors++;
          $display("FAIL %s done actual=%b expected=%b", e.req, done, e.done);
        end
        checks++;
        if (err !== e.err) begin
          errors++;
          $display("FAIL %s err actual=%b expected=%b", e.req, err, e.err);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    drive(1'b1, '0, '0, "R1");
    drive(1'b1, 8'hFF, 8'h00, "R1");
    drive(1'b0, 8'h00, 8'h00, "R3");
    drive(1'b0, 8'h0F, 8'h00, "R4 partial from low");
    drive(1'b0, 8'h01, 8'h10, "R4 partial from low");
    drive(1'b0, 8'hFF, 8'h00, "R2 all ones");
    drive(1'b0, 8'hF0, 8'h00, "R4 partial from high");
    drive(1'b0, 8'h00, 8'h80, "R4 single bit left");
    drive(1'b0, 8'h00, 8'h00, "R3 spacer");
    drive(1'b0, 8'h00, 8'hFF, "R7 all zeros");
    drive(1'b0, 8'h00, 8'h00, "R3 spacer");
    drive(1'b0, 8'hA5, 8'h5A, "R7 mixed data");
    drive(1'b0, 8'h00, 8'h00, "R3 spacer");
    drive(1'b0, 8'h7F, 8'h00, "R4 seven of eight");
    drive(1'b0, 8'hFF, 8'h80, "R5 illegal bit completes");
    drive(1'b0, 8'hFF, 8'h00, "R6 err clears");
    drive(1'b0, 8'h00, 8'h00, "R3 spacer");
    drive(1'b0, 8'h03, 8'h01, "R6 illegal in partial");
    drive(1'b0, 8'h02, 8'h00, "R4 partial hold");
    drive(1'b0, 8'hFF, 8'h00, "R2 again");
    drive(1'b1, 8'hFF, 8'hFF, "R1 reset over held state");
    drive(1'b0, 8'h00, 8'h00, "R3 after reset");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule